// File: doc/BRIEF.md
# Transmit Packet-Number Queue Pair

This block keeps two short first-in first-out queues of packet numbers for a transmit path. The pending queue takes a number from the packet-number register each time the CPU issues an enqueue command. The transmit sequencer reads that queue's head and requests an advance when it is ready for its next frame. After a normal advance the departing number joins the completion queue. It stays there until the CPU acknowledges the transmit interrupt. The CPU reads the completion head through a read port that carries its own empty flag.

When auto-release is selected, an advance drops the pending head without copying it into the completion queue. The block reports two status bits for the interrupt logic: an empty indication for the pending queue and a not-empty indication for the completion queue. Each queue has its own sticky overflow flag, which only a reset clears. All state is held in registers, so every result appears after the clock edge that samples the command.

Top module: `txq_pair`

## Requirements
- R1: After a synchronous active-low reset both queues are empty: `tx_empty`=1, `tx_int`=0, `cmp_empty`=1, and both overflow flags are 0.
- R2: The pending queue is written only when `enq_cmd` is high, with the value of `pn_reg`. It presents its entries on `pend_head` in the order they were enqueued.
- R3: A normal advance (`adv_req`=1, `auto_rel`=0) with the pending queue not empty and room in the completion queue moves the pending head to the tail of the completion queue.
- R4: An advance with `auto_rel`=1 removes the pending head and leaves the completion queue unchanged. A full completion queue never blocks it.
- R5: `ack_cmd` removes the completion head, and `cmp_head` then shows the next older number.
- R6: `tx_empty` is 1 exactly when the pending queue holds no entry. `cmp_empty` is 1 exactly when the completion queue holds no entry. `tx_int` is the inverse of `cmp_empty`.
- R7: An enqueue into a full pending queue, with no pop in the same cycle, is dropped and sets `pend_ovf`, which stays set until reset.
- R8: A normal advance when the completion queue is full and no acknowledge frees a slot in the same cycle leaves both queues unchanged. It sets `cmp_ovf`, which stays set until reset.
- R9: An advance on an empty pending queue and an acknowledge on an empty completion queue change nothing.
- R10: A push and a pop on the same queue in the same cycle both take effect, and this includes a full queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pn_reg | input | PN_W | Packet-number register value used by enqueue |
| enq_cmd | input | 1 | CPU enqueue command |
| adv_req | input | 1 | Transmitter ready for its next frame |
| auto_rel | input | 1 | Auto-release mode: an advance discards the head |
| ack_cmd | input | 1 | CPU transmit-interrupt acknowledge |
| pend_head | output | PN_W | Head of the pending queue |
| tx_empty | output | 1 | Pending queue empty (transmit-empty interrupt bit) |
| cmp_head | output | PN_W | Completion queue read port |
| cmp_empty | output | 1 | Completion read-port empty flag |
| tx_int | output | 1 | Completion queue not empty (transmit interrupt bit) |
| pend_ovf | output | 1 | Sticky pending-queue overflow |
| cmp_ovf | output | 1 | Sticky completion-queue overflow |

## Verification
Every command (enqueue, advance, acknowledge) takes effect at the rising edge that samples it. The heads, the empty and interrupt flags and the sticky overflow flags therefore all reflect that command one cycle later, through one register stage. The bench applies each command at a falling edge and updates its reference queues at the next rising edge. It compares every output at the falling edge that follows, so no check falls in a cycle where a result is still pending. The directed cases drive the full and empty corners in the cycle where they first occur, together with the simultaneous push and pop on a full queue.

// File: rtl/txq_pkg.sv
// Package: shared types for the transmit packet-number queue pair.
// Assumes: nothing beyond IEEE 1800-2017.
package txq_pkg;
    typedef struct packed {
        logic empty;
        logic full;
    } txq_stat_t;
endpackage

// File: rtl/txq_fifo.sv
// Module: txq_fifo
// A count-based circular FIFO of DEPTH words of W bits each. The head word is
// presented combinationally. A pop on an empty FIFO is ignored. A push on a
// full FIFO is accepted only if a pop is accepted in the same cycle.
// Assumes: DEPTH >= 2 and a synchronous active-low reset.
module txq_fifo
    import txq_pkg::*;
#(
    parameter int W     = 6,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    dout,
    output txq_stat_t       stat
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;
    logic          pop_acc;
    logic          push_acc;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Derive the flags and the accepted strobes from the occupancy.
    always_comb begin
        stat.empty = (cnt == '0);
        stat.full  = (cnt == CW'(DEPTH));
        pop_acc    = pop & ~stat.empty;
        push_acc   = push & (~stat.full | pop_acc);
    end

    assign dout = mem[rd_ptr];

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_acc) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (pop_acc)  rd_ptr <= ptr_next(rd_ptr);
            if (push_acc) wr_ptr <= ptr_next(wr_ptr);
            case ({push_acc, pop_acc})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/txq_ctrl.sv
// Module: txq_ctrl
// Turns the CPU and transmitter commands into push and pop strobes for the
// two queues. It couples the advance across both queues and keeps the sticky
// overflow flags.
// Assumes: the queue status it receives is the current-cycle status of each FIFO.
module txq_ctrl
    import txq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enq_cmd,
    input  logic      adv_req,
    input  logic      auto_rel,
    input  logic      ack_cmd,
    input  txq_stat_t pend_stat,
    input  txq_stat_t cmp_stat,
    output logic      pend_push,
    output logic      pend_pop,
    output logic      cmp_push,
    output logic      cmp_pop,
    output logic      pend_ovf,
    output logic      cmp_ovf
);
    logic ack_ok;
    logic cmp_room;
    logic cmp_block;
    logic enq_drop;

    // Decide which queue moves this cycle.
    always_comb begin
        ack_ok    = ack_cmd & ~cmp_stat.empty;
        cmp_room  = ~cmp_stat.full | ack_ok;
        pend_pop  = adv_req & ~pend_stat.empty & (auto_rel | cmp_room);
        cmp_push  = pend_pop & ~auto_rel;
        cmp_pop   = ack_cmd;
        pend_push = enq_cmd;
        cmp_block = adv_req & ~auto_rel & ~pend_stat.empty & ~cmp_room;
        enq_drop  = enq_cmd & pend_stat.full & ~pend_pop;
    end

    // Latch the overflow events until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ovf <= 1'b0;
            cmp_ovf  <= 1'b0;
        end else begin
            if (enq_drop)  pend_ovf <= 1'b1;
            if (cmp_block) cmp_ovf  <= 1'b1;
        end
    end
endmodule

// File: rtl/txq_pair.sv
// Module: txq_pair (top)
// A pending queue fed by the CPU and a completion queue fed by the transmit
// advance. A normal advance moves the pending head into the completion queue.
// An auto-release advance discards it. An acknowledge pops the completion head.
// Assumes: at most one command of each kind per cycle, and a synchronous active-low reset.
module txq_pair
    import txq_pkg::*;
#(
    parameter int PN_W  = 6,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PN_W-1:0] pn_reg,
    input  logic            enq_cmd,
    input  logic            adv_req,
    input  logic            auto_rel,
    input  logic            ack_cmd,
    output logic [PN_W-1:0] pend_head,
    output logic            tx_empty,
    output logic [PN_W-1:0] cmp_head,
    output logic            cmp_empty,
    output logic            tx_int,
    output logic            pend_ovf,
    output logic            cmp_ovf
);
    txq_stat_t pend_stat;
    txq_stat_t cmp_stat;
    logic      pend_push;
    logic      pend_pop;
    logic      cmp_push;
    logic      cmp_pop;

    txq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_cmd   (enq_cmd),
        .adv_req   (adv_req),
        .auto_rel  (auto_rel),
        .ack_cmd   (ack_cmd),
        .pend_stat (pend_stat),
        .cmp_stat  (cmp_stat),
        .pend_push (pend_push),
        .pend_pop  (pend_pop),
        .cmp_push  (cmp_push),
        .cmp_pop   (cmp_pop),
        .pend_ovf  (pend_ovf),
        .cmp_ovf   (cmp_ovf)
    );

    txq_fifo #(.W(PN_W), .DEPTH(DEPTH)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (pend_push),
        .pop   (pend_pop),
        .din   (pn_reg),
        .dout  (pend_head),
        .stat  (pend_stat)
    );

    txq_fifo #(.W(PN_W), .DEPTH(DEPTH)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmp_push),
        .pop   (cmp_pop),
        .din   (pend_head),
        .dout  (cmp_head),
        .stat  (cmp_stat)
    );

    // Drive the status bits seen by the interrupt logic.
    always_comb begin
        tx_empty  = pend_stat.empty;
        cmp_empty = cmp_stat.empty;
        tx_int    = ~cmp_stat.empty;
    end
endmodule

// File: rtl/txq_pair_chk.sv
// Module: txq_pair_chk
// Port-level temporal checks for txq_pair, attached to it with bind.
// Assumes: it is connected to the ports of the top module.
module txq_pair_chk #(
    parameter int PN_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enq_cmd,
    input logic            adv_req,
    input logic            auto_rel,
    input logic            ack_cmd,
    input logic [PN_W-1:0] pend_head,
    input logic            tx_empty,
    input logic [PN_W-1:0] cmp_head,
    input logic            cmp_empty,
    input logic            tx_int,
    input logic            pend_ovf,
    input logic            cmp_ovf
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (tx_empty && cmp_empty && !tx_int && !pend_ovf && !cmp_ovf)); // R1

    AST_ENQ_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        enq_cmd |=> !tx_empty); // R2

    AST_ADV_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && !auto_rel && !tx_empty && cmp_empty)
        |=> (tx_int && cmp_head == $past(pend_head))); // R3

    AST_AUTO_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && auto_rel && !ack_cmd)
        |=> ($stable(cmp_head) && $stable(tx_int))); // R4

    AST_PEND_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ovf |=> pend_ovf); // R7

    AST_CMP_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ovf |=> cmp_ovf); // R8

    AST_PEND_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !enq_cmd) |=> tx_empty); // R9

    AST_CMP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_empty && !(adv_req && !auto_rel && !tx_empty)) |=> cmp_empty); // R9
endmodule

bind txq_pair txq_pair_chk #(.PN_W(PN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_cmd   (enq_cmd),
    .adv_req   (adv_req),
    .auto_rel  (auto_rel),
    .ack_cmd   (ack_cmd),
    .pend_head (pend_head),
    .tx_empty  (tx_empty),
    .cmp_head  (cmp_head),
    .cmp_empty (cmp_empty),
    .tx_int    (tx_int),
    .pend_ovf  (pend_ovf),
    .cmp_ovf   (cmp_ovf)
);

// File: tb/sim_txq_pair.sv
// Bench for txq_pair: directed corner cases followed by seeded random traffic,
// compared against reference queues kept in the bench.
module sim_txq_pair;
    localparam int PN_W  = 6;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PN_W-1:0] pn_reg = '0;
    logic            enq_cmd = 1'b0;
    logic            adv_req = 1'b0;
    logic            auto_rel = 1'b0;
    logic            ack_cmd = 1'b0;
    logic [PN_W-1:0] pend_head;
    logic            tx_empty;
    logic [PN_W-1:0] cmp_head;
    logic            cmp_empty;
    logic            tx_int;
    logic            pend_ovf;
    logic            cmp_ovf;

    int checks = 0;
    int errors = 0;
    int pq[$];
    int cq[$];
    bit m_povf = 1'b0;
    bit m_covf = 1'b0;

    always #5 clk = ~clk;

    txq_pair #(.PN_W(PN_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pn_reg(pn_reg), .enq_cmd(enq_cmd),
        .adv_req(adv_req), .auto_rel(auto_rel), .ack_cmd(ack_cmd),
        .pend_head(pend_head), .tx_empty(tx_empty), .cmp_head(cmp_head),
        .cmp_empty(cmp_empty), .tx_int(tx_int), .pend_ovf(pend_ovf),
        .cmp_ovf(cmp_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference update, written from the requirements.
    task automatic model(input bit e, input bit a, input bit au, input bit k, input int pn);
        bit pe = (pq.size() == 0);
        bit pf = (pq.size() == DEPTH);
        bit ce = (cq.size() == 0);
        bit cf = (cq.size() == DEPTH);
        bit ack_ok = k && !ce;
        bit ppop = a && !pe && (au || !cf || ack_ok);
        bit ppush = e && (!pf || ppop);
        int head = pe ? 0 : pq[0];
        if (a && !au && !pe && cf && !ack_ok) m_covf = 1'b1;
        if (e && pf && !ppop) m_povf = 1'b1;
        if (ppop) void'(pq.pop_front());
        if (ppush) pq.push_back(pn);
        if (ack_ok) void'(cq.pop_front());
        if (ppop && !au) cq.push_back(head);
    endtask

    task automatic compare(input string tag);
        chk({"R6 tx_empty ", tag}, int'(tx_empty), int'(pq.size() == 0));
        chk({"R6 cmp_empty ", tag}, int'(cmp_empty), int'(cq.size() == 0));
        chk({"R6 tx_int ", tag}, int'(tx_int), int'(cq.size() != 0));
        if (pq.size() != 0) chk({"R2 pend_head ", tag}, int'(pend_head), pq[0]);
        if (cq.size() != 0) chk({"R5 cmp_head ", tag}, int'(cmp_head), cq[0]);
        chk({"R7 pend_ovf ", tag}, int'(pend_ovf), int'(m_povf));
        chk({"R8 cmp_ovf ", tag}, int'(cmp_ovf), int'(m_covf));
    endtask

    // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input bit e, input bit a, input bit au, input bit k, input int pn, input string tag);
        enq_cmd  = e;
        adv_req  = a;
        auto_rel = au;
        ack_cmd  = k;
        pn_reg   = PN_W'(pn);
        @(posedge clk);
        model(e, a, au, k, pn);
        @(negedge clk);
        enq_cmd = 1'b0; adv_req = 1'b0; auto_rel = 1'b0; ack_cmd = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pq.delete(); cq.delete();
        m_povf = 1'b0; m_covf = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 tx_int", int'(tx_int), 0);
        chk("R1 cmp_empty", int'(cmp_empty), 1);
        chk("R1 pend_ovf", int'(pend_ovf), 0);
        chk("R1 cmp_ovf", int'(cmp_ovf), 0);

        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, i + 1, "R2 fill");
        step(1, 0, 0, 0, 40, "R7 enqueue into full");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, 0, "R3 transfer");
        step(1, 0, 0, 0, 10, "R2");
        step(1, 0, 0, 0, 11, "R2");
        step(0, 1, 0, 0, 0, "R8 blocked advance");
        step(0, 1, 0, 1, 0, "R10 advance with ack on full");
        step(0, 1, 1, 0, 0, "R4 auto-release");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, "R5 acknowledge");
        step(0, 0, 0, 1, 0, "R9 ack on empty");
        step(0, 1, 0, 0, 0, "R9 advance on empty");
        step(0, 1, 1, 0, 0, "R9 auto advance on empty");
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 20 + i, "R2 refill");
        step(1, 1, 0, 0, 33, "R10 push and pop on full");
        step(1, 1, 1, 0, 34, "R10 auto push and pop on full");

        do_reset();
        compare("R1 second reset");
        for (int n = 0; n < 3000; n++) begin
            step(($urandom_range(0, 99) < 50), ($urandom_range(0, 99) < 40),
                 ($urandom_range(0, 99) < 25), ($urandom_range(0, 99) < 30),
                 int'($urandom_range(0, (1 << PN_W) - 1)), "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule